// File: doc/BRIEF.md
# Delay-Line Lock Controller

This block is the digital control loop of a delay-locked loop built around a tapped delay line. A phase detector outside the block compares the reference clock with the clock returned along the feedback path and reports, on the control clock, whether the feedback edge arrives early or late. The controller turns those reports into an 8-bit tap selection that adds or removes delay one tap at a time. When the edges have stayed aligned for long enough, it raises its lock flag.

Decisions are not taken on every control cycle. A divider sets the update rate, and the early/late inputs are acted on only when it expires. After lock the same periodic corrections carry on, so that the loop follows slow voltage and temperature drift. If a correction is asked for while the tap already sits at either end of the line, the loop cannot follow any further. Lock is then dropped and an error flag is raised until the next reset. A pulse input marks each reference clock edge. If no such edge is seen for a set number of cycles during acquisition, the qualification run is thrown away and must start over.

The state machine has three states. ACQUIRE is entered on reset. It moves to TRACK (transition "qualify") on the update that completes the quiet run. It moves to FAULT (transition "exhaust") on an update that requests a step past the end of the tap range. TRACK also moves to FAULT on "exhaust". FAULT stays where it is and is left only through reset (transition "restart", back to ACQUIRE).

Top module: `dll_lock_ctrl`

## Requirements
- R1: A synchronous reset sets the tap selection to mid-scale (128), clears the lock flag and clears the error flag, and places the controller in ACQUIRE.
- R2: The tap selection can change only on an update event. Update events occur every UPDATE_DIV control cycles (default 8) counted from reset release, the first one on the UPDATE_DIV-th rising edge after reset.
- R3: On an update event, early=1 with late=0 raises the tap by one and late=1 with early=0 lowers it by one. Both high or both low leaves the tap unchanged, and the tap never moves by more than one per event.
- R4: In ACQUIRE, the lock flag rises on the update event that completes LOCK_QUAL (default 4) consecutive update events without a correction.
- R5: Any correction in ACQUIRE restarts the count of quiet update events from zero.
- R6: In TRACK, corrections keep being applied at every update event and the lock flag stays high.
- R7: An update event that requests a raise at tap 255 or a lower at tap 0 leaves the tap unchanged, clears the lock flag and sets the error flag. The controller then stays in FAULT with a frozen tap until reset, and lock and error are never high together.
- R8: In ACQUIRE, a run of MISS_LIMIT (default 12) control cycles without a ref_edge pulse restarts the quiet count, so lock cannot be reached while reference edges are missing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Control clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_edge | input | 1 | One-cycle pulse for each observed reference clock edge |
| early | input | 1 | Phase detector: feedback edge ahead of reference (add delay) |
| late | input | 1 | Phase detector: feedback edge behind reference (remove delay) |
| tap_sel | output | 8 | Selected delay-line tap, 0 to 255 |
| locked | output | 1 | High while the loop is qualified as aligned |
| tap_err | output | 1 | High once the tap range has been exhausted |

## Verification
The bench targets the update boundary itself. It checks the tap on the last cycle before an update event and on the event cycle, so a divider that is off by one shows up as a tap that moves one cycle early or late. A correction is placed three quiet updates into a qualification run: a design that fails to clear its quiet count there locks one update too soon. The tap is driven to both ends of the line. A saturating counter that does not flag the limit would hold lock at 255 or 0, and one that wraps would jump to the opposite end. Reference edges are withheld during acquisition, and a design that ignores the missing edges declares lock anyway.

// File: rtl/dll_lock_pkg.sv
package dll_lock_pkg;

    typedef enum logic [1:0] {
        ST_ACQUIRE = 2'd0,
        ST_TRACK   = 2'd1,
        ST_FAULT   = 2'd2
    } lock_state_t;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_t;

    // Early alone adds delay, late alone removes it, anything else holds.
    function automatic step_t decode_step(input logic is_early, input logic is_late);
        if (is_early && !is_late) begin
            return STEP_UP;
        end else if (is_late && !is_early) begin
            return STEP_DOWN;
        end
        return STEP_HOLD;
    endfunction

endpackage

// File: rtl/dll_rate_div.sv
module dll_rate_div #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = (cnt_q == LAST);
endmodule

// File: rtl/dll_edge_watch.sv
module dll_edge_watch #(
    parameter int MISS_LIMIT = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_edge,
    output logic miss
);
    localparam int GW = (MISS_LIMIT > 2) ? $clog2(MISS_LIMIT) : 1;
    localparam logic [GW-1:0] GAP_LAST = GW'(MISS_LIMIT - 1);

    logic [GW-1:0] gap_q;

    assign miss = !ref_edge && (gap_q == GAP_LAST);

    always_ff @(posedge clk) begin
        if (rst || ref_edge || miss) begin
            gap_q <= '0;
        end else begin
            gap_q <= gap_q + 1'b1;
        end
    end
endmodule

// File: rtl/dll_tap_stepper.sv
module dll_tap_stepper
    import dll_lock_pkg::*;
#(
    parameter int TAP_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_en,
    input  step_t            step_dir,
    output logic [TAP_W-1:0] tap,
    output logic             at_top,
    output logic             at_bot
);
    localparam logic [TAP_W-1:0] TAP_MID = TAP_W'(1) << (TAP_W - 1);

    logic [TAP_W-1:0] tap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tap_q <= TAP_MID;
        end else if (step_en) begin
            unique case (step_dir)
                STEP_UP:   tap_q <= tap_q + 1'b1;
                STEP_DOWN: tap_q <= tap_q - 1'b1;
                default:   tap_q <= tap_q;
            endcase
        end
    end

    assign tap    = tap_q;
    assign at_top = &tap_q;
    assign at_bot = ~|tap_q;
endmodule

// File: rtl/dll_lock_ctrl.sv
module dll_lock_ctrl
    import dll_lock_pkg::*;
#(
    parameter int TAP_W      = 8,
    parameter int UPDATE_DIV = 8,
    parameter int LOCK_QUAL  = 4,
    parameter int MISS_LIMIT = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_edge,
    input  logic             early,
    input  logic             late,
    output logic [TAP_W-1:0] tap_sel,
    output logic             locked,
    output logic             tap_err
);
    localparam int QW = $clog2(LOCK_QUAL + 1);
    localparam logic [QW-1:0] QUIET_LAST = QW'(LOCK_QUAL - 1);

    lock_state_t state_q, state_d;
    logic [QW-1:0] quiet_q, quiet_d;
    logic   tick, miss, at_top, at_bot, hit_limit, step_en;
    step_t  step;

    dll_rate_div #(.DIV(UPDATE_DIV)) u_div (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    dll_edge_watch #(.MISS_LIMIT(MISS_LIMIT)) u_watch (
        .clk      (clk),
        .rst      (rst),
        .ref_edge (ref_edge),
        .miss     (miss)
    );

    assign step      = decode_step(early, late);
    assign hit_limit = tick && (state_q != ST_FAULT) &&
                       (((step == STEP_UP) && at_top) || ((step == STEP_DOWN) && at_bot));
    assign step_en   = tick && (state_q != ST_FAULT) && (step != STEP_HOLD) && !hit_limit;

    dll_tap_stepper #(.TAP_W(TAP_W)) u_tap (
        .clk      (clk),
        .rst      (rst),
        .step_en  (step_en),
        .step_dir (step),
        .tap      (tap_sel),
        .at_top   (at_top),
        .at_bot   (at_bot)
    );

    // Next state and quiet-run count
    always_comb begin
        state_d = state_q;
        quiet_d = '0;
        unique case (state_q)
            ST_ACQUIRE: begin
                if (hit_limit) begin
                    state_d = ST_FAULT;                 // exhaust
                end else if (miss) begin
                    quiet_d = '0;
                end else if (tick) begin
                    if (step != STEP_HOLD) begin
                        quiet_d = '0;
                    end else if (quiet_q == QUIET_LAST) begin
                        state_d = ST_TRACK;             // qualify
                    end else begin
                        quiet_d = quiet_q + 1'b1;
                    end
                end else begin
                    quiet_d = quiet_q;
                end
            end
            ST_TRACK: begin
                if (hit_limit) begin
                    state_d = ST_FAULT;                 // exhaust
                end
            end
            ST_FAULT: begin
                state_d = ST_FAULT;
            end
            default: begin
                state_d = ST_ACQUIRE;
            end
        endcase
    end

    // State register (restart on reset)
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_ACQUIRE;
            quiet_q <= '0;
        end else begin
            state_q <= state_d;
            quiet_q <= quiet_d;
        end
    end

    // Outputs
    always_comb begin
        locked  = (state_q == ST_TRACK);
        tap_err = (state_q == ST_FAULT);
    end
endmodule

// File: rtl/dll_lock_chk.sv
module dll_lock_chk #(
    parameter int TAP_W      = 8,
    parameter int UPDATE_DIV = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [TAP_W-1:0] tap_sel,
    input logic             locked,
    input logic             tap_err
);
    localparam int CW = (UPDATE_DIV > 2) ? $clog2(UPDATE_DIV) : 1;
    localparam logic [TAP_W-1:0] MID = TAP_W'(1) << (TAP_W - 1);

    logic [CW-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst || (phase_q == CW'(UPDATE_DIV - 1))) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (tap_sel == MID) && !locked && !tap_err);

    // R2
    update_align_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && (tap_sel != $past(tap_sel))) |-> (phase_q == '0));

    // R3
    single_step_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (tap_sel == $past(tap_sel)) ||
                        (tap_sel == $past(tap_sel) + 1'b1) ||
                        (tap_sel == $past(tap_sel) - 1'b1));

    // R6
    lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
        locked |=> locked || tap_err);

    // R7
    fault_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        tap_err |=> tap_err && $stable(tap_sel));

    // R7
    flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(locked && tap_err));
endmodule

bind dll_lock_ctrl dll_lock_chk #(.TAP_W(TAP_W), .UPDATE_DIV(UPDATE_DIV)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .tap_sel (tap_sel),
    .locked  (locked),
    .tap_err (tap_err)
);

// File: tb/dll_lock_ctrl_tb.sv
module dll_lock_ctrl_tb;
    localparam int UPDATE_DIV = 8;
    localparam int LOCK_QUAL  = 4;
    localparam int MISS_LIMIT = 12;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_edge = 1'b0;
    logic       early = 1'b0;
    logic       late = 1'b0;
    logic [7:0] tap_sel;
    logic       locked, tap_err;

    int  errors = 0;
    int  checks = 0;
    bit  ref_on = 1'b1;
    bit  ref_rand = 1'b0;
    bit  done = 1'b0;
    int  ref_phase = 0;

    // reference model state: 0 acquire, 1 track, 2 fault
    int m_tap = 128, m_state = 0, m_quiet = 0, m_div = 0, m_gap = 0;

    always #5 clk = ~clk;

    dll_lock_ctrl #(.UPDATE_DIV(UPDATE_DIV), .LOCK_QUAL(LOCK_QUAL), .MISS_LIMIT(MISS_LIMIT)) u_dut (
        .clk(clk), .rst(rst), .ref_edge(ref_edge), .early(early), .late(late),
        .tap_sel(tap_sel), .locked(locked), .tap_err(tap_err)
    );

    function automatic int step_of(input logic e, input logic l);
        if (e && !l) return 1;
        if (l && !e) return -1;
        return 0;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // reference edge source
    always @(negedge clk) begin
        ref_phase <= ref_phase + 1;
        if (ref_rand) ref_edge <= (($urandom % 3) == 0);
        else          ref_edge <= ref_on && ((ref_phase % 4) == 0);
    end

    // model built from the requirements
    always @(posedge clk) begin
        if (rst) begin
            m_tap = 128; m_state = 0; m_quiet = 0; m_div = 0; m_gap = 0;
        end else begin
            bit tk, ms;
            int st;
            tk = (m_div == UPDATE_DIV - 1);
            ms = !ref_edge && (m_gap == MISS_LIMIT - 1);
            m_div = tk ? 0 : m_div + 1;
            m_gap = (ref_edge || ms) ? 0 : m_gap + 1;
            st = step_of(early, late);
            if (tk && m_state != 2) begin
                if ((st == 1 && m_tap == 255) || (st == -1 && m_tap == 0)) begin
                    m_state = 2;
                end else begin
                    m_tap = m_tap + st;
                    if (m_state == 0) begin
                        if (ms || st != 0) m_quiet = 0;
                        else if (m_quiet == LOCK_QUAL - 1) begin m_state = 1; m_quiet = 0; end
                        else m_quiet++;
                    end
                end
            end else if (m_state == 0 && ms) begin
                m_quiet = 0;
            end
        end
    end

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (!done) begin
            chk("R3 tap", tap_sel, m_tap);
            chk("R4 locked", locked, m_state == 1);
            chk("R7 tap_err", tap_err, m_state == 2);
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        wait_n(3);
        rst = 1'b0;
    endtask

    task automatic drive(input logic e, input logic l);
        early = e; late = l;
    endtask

    initial begin
        void'($urandom(32'd1234));
        wait_n(3);
        // R1 reset state
        chk("R1 tap mid", tap_sel, 128);
        chk("R1 locked low", locked, 0);
        chk("R1 err low", tap_err, 0);
        rst = 1'b0;

        drive(1, 0); wait_n(40);
        chk("R3 early raises", tap_sel, 133);
        wait_n(7);
        chk("R2 no step before update", tap_sel, 133);
        wait_n(1);
        chk("R2 step on update", tap_sel, 134);
        drive(0, 1); wait_n(16);
        chk("R3 late lowers", tap_sel, 132);
        drive(1, 1); wait_n(8);
        chk("R3 both holds", tap_sel, 132);
        drive(0, 0); wait_n(16);
        drive(1, 0); wait_n(8);
        drive(0, 0); wait_n(24);
        chk("R5 correction restarts run", locked, 0);
        wait_n(8);
        chk("R4 lock after quiet run", locked, 1);
        chk("R4 tap at lock", tap_sel, 133);

        drive(0, 1); wait_n(16);
        chk("R6 track corrects", tap_sel, 131);
        chk("R6 lock held", locked, 1);
        drive(1, 0); wait_n(992);
        chk("R6 top reached", tap_sel, 255);
        chk("R6 still locked", locked, 1);
        wait_n(8);
        chk("R7 top exhaust err", tap_err, 1);
        chk("R7 top exhaust lock", locked, 0);
        chk("R7 top tap held", tap_sel, 255);
        drive(0, 1); wait_n(16);
        chk("R7 frozen in fault", tap_sel, 255);
        chk("R7 err sticky", tap_err, 1);

        // R8 missing reference edges
        drive(0, 0); do_reset();
        ref_on = 1'b0; wait_n(80);
        chk("R8 no lock without ref", locked, 0);
        ref_on = 1'b1; wait_n(64);
        chk("R8 lock after ref resumes", locked, 1);

        // lower end
        do_reset(); drive(0, 1); wait_n(1024);
        chk("R7 bottom reached", tap_sel, 0);
        wait_n(8);
        chk("R7 bottom exhaust err", tap_err, 1);
        chk("R7 bottom tap held", tap_sel, 0);

        // constrained random phase
        drive(0, 0); do_reset(); ref_rand = 1'b1;
        for (int i = 0; i < 6000; i++) begin
            int r;
            r = $urandom % 8;
            early = (r == 1) || (r == 3);
            late  = (r == 2) || (r == 3);
            rst   = (($urandom % 700) == 0);
            @(negedge clk);
        end
        rst = 1'b0;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        done = 1'b1;
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule